// File: doc/BRIEF.md
# Shaped Dither Generator and Stage Router

This block supplies pseudo-random dither to a three-stage cascaded (MASH) delta-sigma modulator. A linear feedback shift register produces one random bit per enabled clock. Depending on the selected mode, that bit is either passed unshaped or passed through a first- or second-order high-pass difference filter. It is then delivered to one or two of the three stage inputs as a small two's-complement word. Stages that the mode does not select receive zero.

Injecting unshaped dither at the second stage gives first-order shaping at the modulator output, and injecting it at the second and third stages together gives the multi-point scheme. The filtered modes shape the dither inside this block before it enters the first stage. The mode can change at any time. A change restarts the filter so that no samples from the previous mode leak into the new one. The seed can be loaded at run time so that each channel gets its own sequence.

Top module: `dither_router`

## Requirements
- R1: The random source is a Fibonacci LFSR of LFSR_W bits (default 23). On each advance it shifts left, and bit 0 takes the XOR of the state bits selected by TAPS (default: bits 22 and 17, polynomial x^23+x^18+1). The dither bit d is the current MSB. With maximal taps the bit sequence repeats every 2^LFSR_W-1 advances, and each period holds 2^(LFSR_W-1) ones.
- R2: A cycle with seed_load high loads seed_val into the LFSR, or DEFAULT_SEED if seed_val is zero. It also zeroes all three outputs and the filter history, ignores en, and records the current mode. Reset does the same with DEFAULT_SEED and records mode 0.
- R3: Mode 3'd0 (unshaped, first stage): dith1 = d (0 or 1); dith2 = dith3 = 0.
- R4: Mode 3'd1 (second stage): dith2 = d; dith1 = dith3 = 0.
- R5: Mode 3'd2 (multi-point): dith2 = dith3 = d; dith1 = 0.
- R6: Mode 3'd3 (second-order shaped): dith1 = d[n] - 2*d[n-1] + d[n-2], which lies in -2..+2; dith2 = dith3 = 0.
- R7: Mode 3'd4 (first-order shaped): dith1 = d[n] - d[n-1], which lies in -1..+1; dith2 = dith3 = 0.
- R8: Modes 3'd5 to 3'd7 drive all three outputs to zero while the LFSR keeps advancing.
- R9: On the first enabled edge whose mode differs from the recorded mode, the new mode applies at once and the filter takes d[n-1] = d[n-2] = 0.
- R10: With en low and seed_load low, the outputs and the LFSR state hold.
- R11: Outputs are registered. The value from the LFSR state before an enabled edge appears right after that edge, and the LFSR advances on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance enable |
| mode | input | 3 | Injection and shaping mode |
| seed_load | input | 1 | Load seed_val into the LFSR |
| seed_val | input | LFSR_W | Seed value (zero selects DEFAULT_SEED) |
| dith1 | output | DW | Dither word for stage 1, two's complement |
| dith2 | output | DW | Dither word for stage 2, two's complement |
| dith3 | output | DW | Dither word for stage 3, two's complement |

## Verification
The bench builds the block with LFSR_W = 7, TAPS = 7'h60 (x^7+x^6+1) and DEFAULT_SEED = 7'h5A. The short 127-step period lets a directed test observe two full wraps and count the ones per period. The narrow width also makes the zero-seed substitution easy to follow. A bench model of the shift register and the difference filters predicts every output word. This covers each mode, the restart after a mode change, the reserved codes and the hold under a low enable.

// File: rtl/dither_router.sv
`timescale 1ns/1ps
module dither_router #(
  parameter int LFSR_W = 23,
  parameter logic [LFSR_W-1:0] TAPS = LFSR_W'(23'h420000),
  parameter logic [LFSR_W-1:0] DEFAULT_SEED = LFSR_W'(1),
  parameter int DW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [2:0]           mode,
  input  logic                 seed_load,
  input  logic [LFSR_W-1:0]    seed_val,
  output logic signed [DW-1:0] dith1,
  output logic signed [DW-1:0] dith2,
  output logic signed [DW-1:0] dith3
);
  localparam logic [2:0] M_UNSHAPED = 3'd0;
  localparam logic [2:0] M_STAGE2   = 3'd1;
  localparam logic [2:0] M_MULTI    = 3'd2;
  localparam logic [2:0] M_SHAPE2   = 3'd3;
  localparam logic [2:0] M_SHAPE1   = 3'd4;
  localparam logic signed [DW-1:0] ZERO = '0;

  function automatic logic signed [DW-1:0] ext(input logic b);
    return {{(DW-1){1'b0}}, b};
  endfunction

  logic [LFSR_W-1:0] lfsr;
  logic [2:0]        mode_q;
  logic              h1, h2;

  wire d       = lfsr[LFSR_W-1];
  wire fb      = ^(lfsr & TAPS);
  wire restart = (mode != mode_q);
  wire p1      = restart ? 1'b0 : h1;
  wire p2      = restart ? 1'b0 : h2;

  logic signed [DW-1:0] raw, fo1, fo2;
  assign raw = ext(d);
  assign fo1 = raw - ext(p1);
  assign fo2 = raw - (ext(p1) <<< 1) + ext(p2);

  logic signed [DW-1:0] n1, n2, n3;
  always_comb begin
    n1 = ZERO;
    n2 = ZERO;
    n3 = ZERO;
    case (mode)
      M_UNSHAPED: n1 = raw;
      M_STAGE2:   n2 = raw;
      M_MULTI:    begin n2 = raw; n3 = raw; end
      M_SHAPE2:   n1 = fo2;
      M_SHAPE1:   n1 = fo1;
      default:    ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr   <= DEFAULT_SEED;
      mode_q <= M_UNSHAPED;
      h1     <= 1'b0;
      h2     <= 1'b0;
      dith1  <= ZERO;
      dith2  <= ZERO;
      dith3  <= ZERO;
    end else if (seed_load) begin
      lfsr   <= (seed_val == '0) ? DEFAULT_SEED : seed_val;
      mode_q <= mode;
      h1     <= 1'b0;
      h2     <= 1'b0;
      dith1  <= ZERO;
      dith2  <= ZERO;
      dith3  <= ZERO;
    end else if (en) begin
      lfsr   <= {lfsr[LFSR_W-2:0], fb};
      mode_q <= mode;
      h1     <= d;
      h2     <= p1;
      dith1  <= n1;
      dith2  <= n2;
      dith3  <= n3;
    end
  end
endmodule

// File: rtl/dither_router_chk.sv
`timescale 1ns/1ps
module dither_router_chk #(
  parameter int DW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic [2:0]           mode,
  input logic                 seed_load,
  input logic signed [DW-1:0] dith1,
  input logic signed [DW-1:0] dith2,
  input logic signed [DW-1:0] dith3
);
  wire adv = en && !seed_load;

  assert_seed_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (dith1 == 0 && dith2 == 0 && dith3 == 0));

  assert_unshaped_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode == 3'd0) |=> ((dith1 == 0 || dith1 == 1) && dith2 == 0 && dith3 == 0));

  assert_stage2_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode == 3'd1) |=> ((dith2 == 0 || dith2 == 1) && dith1 == 0 && dith3 == 0));

  assert_multi_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode == 3'd2) |=> (dith2 == dith3 && dith1 == 0));

  assert_shape2_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode == 3'd3) |=> (dith1 >= -2 && dith1 <= 2 && dith2 == 0 && dith3 == 0));

  assert_shape1_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode == 3'd4) |=> (dith1 >= -1 && dith1 <= 1 && dith2 == 0 && dith3 == 0));

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode >= 3'd5) |=> (dith1 == 0 && dith2 == 0 && dith3 == 0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !seed_load) |=> ($stable(dith1) && $stable(dith2) && $stable(dith3)));
endmodule

bind dither_router dither_router_chk #(.DW(DW)) u_chk (.*);

// File: tb/dither_router_bench.sv
`timescale 1ns/1ps
module dither_router_bench;
  localparam int W = 7;
  localparam logic [W-1:0] TP  = 7'h60;
  localparam logic [W-1:0] DEF = 7'h5A;
  localparam int DW = 3;
  localparam int PER = 127;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [2:0] mode = 3'd0;
  logic seed_load = 1'b0;
  logic [W-1:0] seed_val = '0;
  logic signed [DW-1:0] dith1, dith2, dith3;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [W-1:0] s;
  logic h1, h2;
  logic [2:0] mcur;

  always #10 clk = ~clk;

  dither_router #(.LFSR_W(W), .TAPS(TP), .DEFAULT_SEED(DEF), .DW(DW)) u_dither_router (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .seed_load(seed_load),
    .seed_val(seed_val), .dith1(dith1), .dith2(dith2), .dith3(dith3));

  function automatic logic [W-1:0] nxt(input logic [W-1:0] x);
    return {x[W-2:0], ^(x & TP)};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] m, input string req, output int o1);
    int e1, e2, e3, d, p1, p2;
    mode = m; en = 1'b1; seed_load = 1'b0;
    d  = int'(s[W-1]);
    p1 = (m != mcur) ? 0 : int'(h1);
    p2 = (m != mcur) ? 0 : int'(h2);
    e1 = 0; e2 = 0; e3 = 0;
    case (m)
      3'd0: e1 = d;
      3'd1: e2 = d;
      3'd2: begin e2 = d; e3 = d; end
      3'd3: e1 = d - 2*p1 + p2;
      3'd4: e1 = d - p1;
      default: ;
    endcase
    h2 = p1[0]; h1 = s[W-1]; mcur = m; s = nxt(s);
    @(posedge clk); @(negedge clk);
    chk(req, "dith1", int'(dith1), e1);
    chk(req, "dith2", int'(dith2), e2);
    chk(req, "dith3", int'(dith3), e3);
    o1 = int'(dith1);
  endtask

  task automatic load_seed(input logic [W-1:0] v, input logic [2:0] m);
    mode = m; seed_val = v; seed_load = 1'b1; en = 1'b0;
    @(posedge clk); @(negedge clk);
    seed_load = 1'b0;
    chk("R2", "dith1 after load", int'(dith1), 0);
    chk("R2", "dith2 after load", int'(dith2), 0);
    chk("R2", "dith3 after load", int'(dith3), 0);
    s = (v == '0) ? DEF : v; h1 = 0; h2 = 0; mcur = m;
  endtask

  task automatic t_reset;
    int o;
    repeat (3) @(negedge clk);
    chk("R2", "dith1 in reset", int'(dith1), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "dith1 after reset", int'(dith1), 0);
    chk("R2", "dith3 after reset", int'(dith3), 0);
    s = DEF; h1 = 0; h2 = 0; mcur = 3'd0;
    step(3'd0, "R11", o);
    chk("R11", "first bit is seed MSB", o, int'(DEF[W-1]));
  endtask

  task automatic t_period_r1;
    int seq [2*PER];
    int ones;
    load_seed(7'h01, 3'd0);
    for (int k = 0; k < 2*PER; k++) step(3'd0, "R1", seq[k]);
    ones = 0;
    for (int k = 0; k < PER; k++) begin
      ones += seq[k];
      chk("R1", "wrap repeat", seq[k+PER], seq[k]);
    end
    chk("R1", "ones per period", ones, 64);
  endtask

  task automatic t_zero_seed;
    int o;
    load_seed('0, 3'd0);
    for (int k = 0; k < 12; k++) step(3'd0, "R2", o);
  endtask

  task automatic t_routes;
    int o;
    load_seed(7'h33, 3'd1);
    for (int k = 0; k < 20; k++) step(3'd1, "R4", o);
    for (int k = 0; k < 20; k++) step(3'd2, "R5", o);
    for (int k = 0; k < 20; k++) step(3'd0, "R3", o);
  endtask

  task automatic t_shaping;
    int o;
    load_seed(7'h2D, 3'd3);
    for (int k = 0; k < 60; k++) step(3'd3, "R6", o);
    load_seed(7'h71, 3'd4);
    for (int k = 0; k < 40; k++) step(3'd4, "R7", o);
  endtask

  task automatic t_mode_change_r9;
    int o;
    load_seed(7'h1F, 3'd3);
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 9; k++) step(3'd3, "R6", o);
      step(3'd4, "R9", o);
      for (int k = 0; k < 5; k++) step(3'd4, "R7", o);
      step(3'd3, "R9", o);
      step(3'd3, "R9", o);
    end
  endtask

  task automatic t_reserved_r8;
    int o;
    load_seed(7'h44, 3'd0);
    for (int m = 5; m < 8; m++)
      for (int k = 0; k < 7; k++) step(3'(m), "R8", o);
    for (int k = 0; k < 10; k++) step(3'd0, "R8 continuation", o);
  endtask

  task automatic t_enable_r10;
    int o, a1, a2, a3;
    load_seed(7'h0B, 3'd3);
    for (int k = 0; k < 6; k++) step(3'd3, "R6", o);
    a1 = int'(dith1); a2 = int'(dith2); a3 = int'(dith3);
    en = 1'b0;
    repeat (8) begin
      @(posedge clk); @(negedge clk);
      chk("R10", "dith1 hold", int'(dith1), a1);
      chk("R10", "dith2 hold", int'(dith2), a2);
      chk("R10", "dith3 hold", int'(dith3), a3);
    end
    for (int k = 0; k < 10; k++) step(3'd3, "R10 resume", o);
  endtask

  initial begin
    t_reset();
    t_period_r1();
    t_zero_seed();
    t_routes();
    t_shaping();
    t_mode_change_r9();
    t_reserved_r8();
    t_enable_r10();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule